// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block runs the data phase of one storage command. It reads a table of 16-byte region descriptors from memory, one descriptor at a time. For each descriptor it hands an address-plus-length burst to a downstream data mover and then waits for the mover to report completion. The command can begin at any byte offset into the table. The last burst is trimmed so that the bursts together cover exactly the requested byte count.

A descriptor can ask for a completion interrupt. That request is raised as a sticky status bit only when the whole command finishes cleanly. A command that ends with a mover error, or that runs out of descriptors before the byte count is met, never raises it. A software-facing register file would clear the status bit through a write-one-to-clear pulse and gate the interrupt line through an enable input.

Top module: `sg_walker`

## Requirements
- R1: While reset is high and on the first cycle after it, `done`, `err`, `irq_sts`, `irq_out`, `rd_en` and `bst_valid` are all low.
- R2: Entry i sits at `tbl_base + 16*i`. The low address dword is at +0, the high address dword at +4 and the flags/size dword at +12. The segment length is bits 21:0 plus one. Bit 31 requests the completion interrupt. Bits 30:22 change neither the length nor the request.
- R3: Exactly one burst is issued per used descriptor, in ascending table order. Each request holds `bst_addr` and `bst_len` stable until `bst_ready`. The next descriptor is fetched only after `bst_done`.
- R4: Descriptors lying wholly below `start_ofs` are skipped. The first burst starts at the containing descriptor's address plus the remaining in-descriptor offset, with its length reduced by the same amount.
- R5: The last burst is cut so that the burst lengths sum to `xfer_len`, and no further descriptor is used. A `xfer_len` of zero ends the command with no burst and no error.
- R6: If the entries run out before `xfer_len` bytes are issued (including `entry_cnt` of zero), the command ends with `err` high and no interrupt status.
- R7: A `bst_done` with `bst_err` high ends the command with `err` high. No further burst is issued and no interrupt status is set.
- R8: `irq_sts` is set in the cycle `done` rises only when the command succeeded and at least one issued descriptor had bit 31 set. Bit 31 of a skipped descriptor has no effect.
- R9: `irq_sts` stays set until an `irq_clr` pulse. A set in the same cycle wins over a clear. `irq_out` equals `irq_sts` AND `irq_en` one cycle later, and `irq_en` has no effect on `irq_sts`.
- R10: `done` is a one-cycle pulse. `err` is valid with it and holds until the next accepted start. A `start` while a command is running is ignored.
- R11: A reset in the middle of a command abandons it: no later burst and no interrupt status come from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken only when idle |
| tbl_base | input | AW | Byte address of descriptor 0 |
| entry_cnt | input | CW | Number of descriptors in the table |
| start_ofs | input | XW | Byte offset into the table's data where the command begins |
| xfer_len | input | XW | Bytes the command moves |
| rd_en | output | 1 | Memory read strobe, one dword |
| rd_addr | output | AW | Byte address of the dword read |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | 32 | Read data |
| bst_valid | output | 1 | Burst request valid |
| bst_addr | output | 64 | Burst start address |
| bst_len | output | 23 | Burst length in bytes |
| bst_ready | input | 1 | Burst request accepted |
| bst_done | input | 1 | Accepted burst finished |
| bst_err | input | 1 | Finished burst failed, valid with `bst_done` |
| irq_en | input | 1 | Interrupt line enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| irq_sts | output | 1 | Sticky descriptor-processed status |
| irq_out | output | 1 | Gated interrupt line |
| done | output | 1 | Command finished, one-cycle pulse |
| err | output | 1 | Command failed, valid with `done` |

## Verification
Directed tables separate the ways a command ends: a clean full walk, a walk that starts inside the second descriptor, a byte count that cuts the table short, a table that is too short, a mover error on a later burst, and an empty command. Each of these shows whether the interrupt request of a flagged descriptor survives to `irq_sts`. Random tables carry random reserved bits, flag patterns, offsets, byte counts, stalls and error positions. They are compared burst by burst against a bench model, so any offset, trimming or ordering slip shows up as a wrong address or length. Further directed runs hold the clear pulse across the set cycle, drive the enable low, restart the block while it is busy, and reset it in the middle of a walk.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int LEN_BITS    = 22;
  localparam int IOC_BIT     = 31;
  localparam int ENTRY_SHIFT = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ISSUE, ST_WAIT, ST_NEXT, ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic [63:0] addr;
    logic        ioc;
    logic [LEN_BITS-1:0] len_f;
  } desc_t;
endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] ent_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  output logic          desc_valid,
  output desc_t         desc
);
  logic          busy;
  logic [1:0]    wsel;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      wsel       <= 2'd0;
      base_q     <= '0;
      rd_en      <= 1'b0;
      rd_addr    <= '0;
      desc_valid <= 1'b0;
      desc       <= '0;
    end else begin
      rd_en      <= 1'b0;
      desc_valid <= 1'b0;
      if (go && !busy) begin
        busy    <= 1'b1;
        wsel    <= 2'd0;
        base_q  <= ent_addr;
        rd_en   <= 1'b1;
        rd_addr <= ent_addr;
      end else if (busy && rd_valid) begin
        case (wsel)
          2'd0: begin
            desc.addr[31:0] <= rd_data;
            rd_en   <= 1'b1;
            rd_addr <= base_q + AW'(4);
            wsel    <= 2'd1;
          end
          2'd1: begin
            desc.addr[63:32] <= rd_data;
            rd_en   <= 1'b1;
            rd_addr <= base_q + AW'(12);
            wsel    <= 2'd2;
          end
          default: begin
            desc.ioc   <= rd_data[IOC_BIT];
            desc.len_f <= rd_data[LEN_BITS-1:0];
            busy       <= 1'b0;
            desc_valid <= 1'b1;
            wsel       <= 2'd0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sgw_seg.sv
module sgw_seg
  import sgw_pkg::*;
#(
  parameter int XW   = 32,
  parameter int LENW = LEN_BITS + 1
) (
  input  desc_t           desc,
  input  logic [XW-1:0]   skip,
  input  logic [XW-1:0]   remain,
  output logic            skip_all,
  output logic [XW-1:0]   skip_nx,
  output logic [63:0]     seg_addr,
  output logic [LENW-1:0] seg_len,
  output logic            ioc
);
  logic [LENW-1:0] full_len;
  logic [LENW-1:0] part;

  always_comb begin
    full_len = {1'b0, desc.len_f} + LENW'(1);
    skip_all = (skip >= XW'(full_len));
    skip_nx  = skip_all ? (skip - XW'(full_len)) : '0;
    part     = full_len - skip[LENW-1:0];
    seg_len  = (XW'(part) > remain) ? remain[LENW-1:0] : part;
    seg_addr = desc.addr + 64'(skip);
    ioc      = desc.ioc;
  end
endmodule

// File: rtl/sgw_irq.sv
module sgw_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic sts,
  output logic line
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sts  <= 1'b0;
      line <= 1'b0;
    end else begin
      if (set)      sts <= 1'b1;
      else if (clr) sts <= 1'b0;
      line <= sts & en;
    end
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int AW = 64,
  parameter int CW = 16,
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] tbl_base,
  input  logic [CW-1:0] entry_cnt,
  input  logic [XW-1:0] start_ofs,
  input  logic [XW-1:0] xfer_len,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  output logic          bst_valid,
  output logic [63:0]   bst_addr,
  output logic [22:0]   bst_len,
  input  logic          bst_ready,
  input  logic          bst_done,
  input  logic          bst_err,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic          irq_sts,
  output logic          irq_out,
  output logic          done,
  output logic          err
);
  localparam int LENW = LEN_BITS + 1;

  walk_st_e        st;
  logic [CW-1:0]   idx;
  logic [CW-1:0]   cnt_q;
  logic [AW-1:0]   base_q;
  logic [XW-1:0]   remain;
  logic [XW-1:0]   skip;
  logic            pend;
  logic            err_r;
  logic            cur_ioc;
  logic            fetch_go;
  logic [AW-1:0]   ent_addr;

  logic            desc_valid;
  desc_t           desc;
  logic            skip_all;
  logic [XW-1:0]   skip_nx;
  logic [63:0]     seg_addr;
  logic [LENW-1:0] seg_len;
  logic            seg_ioc;
  logic            irq_set;

  assign ent_addr = base_q + (AW'(idx) << ENTRY_SHIFT);
  assign irq_set  = (st == ST_DONE) && !err_r && pend;

  sgw_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .go(fetch_go), .ent_addr(ent_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .desc_valid(desc_valid), .desc(desc)
  );

  sgw_seg #(.XW(XW), .LENW(LENW)) u_seg (
    .desc(desc), .skip(skip), .remain(remain),
    .skip_all(skip_all), .skip_nx(skip_nx),
    .seg_addr(seg_addr), .seg_len(seg_len), .ioc(seg_ioc)
  );

  sgw_irq u_irq (
    .clk(clk), .rst(rst), .set(irq_set), .clr(irq_clr), .en(irq_en),
    .sts(irq_sts), .line(irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      idx       <= '0;
      cnt_q     <= '0;
      base_q    <= '0;
      remain    <= '0;
      skip      <= '0;
      pend      <= 1'b0;
      err_r     <= 1'b0;
      cur_ioc   <= 1'b0;
      fetch_go  <= 1'b0;
      bst_valid <= 1'b0;
      bst_addr  <= '0;
      bst_len   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done     <= 1'b0;
      fetch_go <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            base_q <= tbl_base;
            cnt_q  <= entry_cnt;
            remain <= xfer_len;
            skip   <= start_ofs;
            idx    <= '0;
            pend   <= 1'b0;
            err_r  <= 1'b0;
            err    <= 1'b0;
            if (xfer_len == '0) begin
              st <= ST_DONE;
            end else if (entry_cnt == '0) begin
              err_r <= 1'b1;
              st    <= ST_DONE;
            end else begin
              fetch_go <= 1'b1;
              st       <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (desc_valid) begin
            if (skip_all) begin
              skip <= skip_nx;
              st   <= ST_NEXT;
            end else begin
              skip      <= '0;
              bst_valid <= 1'b1;
              bst_addr  <= seg_addr;
              bst_len   <= seg_len;
              cur_ioc   <= seg_ioc;
              st        <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (bst_ready) begin
            bst_valid <= 1'b0;
            st        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (bst_done) begin
            if (bst_err) begin
              err_r <= 1'b1;
              st    <= ST_DONE;
            end else begin
              remain <= remain - XW'(bst_len);
              if (cur_ioc) pend <= 1'b1;
              st <= ST_NEXT;
            end
          end
        end
        ST_NEXT: begin
          if (remain == '0) begin
            st <= ST_DONE;
          end else if (idx == cnt_q - CW'(1)) begin
            err_r <= 1'b1;
            st    <= ST_DONE;
          end else begin
            idx      <= idx + CW'(1);
            fetch_go <= 1'b1;
            st       <= ST_FETCH;
          end
        end
        default: begin
          done <= 1'b1;
          err  <= err_r;
          pend <= 1'b0;
          st   <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          bst_valid,
  input logic [63:0]   bst_addr,
  input logic [22:0]   bst_len,
  input logic          bst_ready,
  input logic          irq_en,
  input logic          irq_clr,
  input logic          irq_sts,
  input logic          irq_out,
  input logic          done,
  input logic          err
);
  AST_BST_HOLD: assert property (@(posedge clk) disable iff (rst)
    bst_valid && !bst_ready |=> bst_valid && $stable(bst_addr) && $stable(bst_len)); // R3

  AST_BST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    bst_valid |-> (bst_len != 23'd0) && (!bst_len[22] || (bst_len[21:0] == 22'd0))); // R2

  AST_FETCH_BURST_APART: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && bst_valid)); // R3

  AST_RD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr[1:0] == 2'b00)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_IRQ_ONLY_OK: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_sts) |-> done && !err); // R8

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> (done || !irq_sts)); // R9

  AST_IRQ_LINE_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(irq_en) && $past(irq_sts)); // R9
endmodule

bind sg_walker sg_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
  .bst_valid(bst_valid), .bst_addr(bst_addr), .bst_len(bst_len),
  .bst_ready(bst_ready), .irq_en(irq_en), .irq_clr(irq_clr),
  .irq_sts(irq_sts), .irq_out(irq_out), .done(done), .err(err)
);

// File: tb/sg_walker_bench.sv
`timescale 1ns/1ps
module sg_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] tbl_base = 64'h0000_0040_0000_1000;
  logic [15:0] entry_cnt = '0;
  logic [31:0] start_ofs = '0;
  logic [31:0] xfer_len = '0;
  logic        rd_en;
  logic [63:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        bst_valid;
  logic [63:0] bst_addr;
  logic [22:0] bst_len;
  logic        bst_ready = 1'b1;
  logic        bst_done = 1'b0;
  logic        bst_err = 1'b0;
  logic        irq_en = 1'b0;
  logic        irq_clr = 1'b0;
  logic        irq_sts;
  logic        irq_out;
  logic        done;
  logic        err;

  always #2 clk = ~clk;

  sg_walker u_sg_walker (
    .clk(clk), .rst(rst), .start(start), .tbl_base(tbl_base),
    .entry_cnt(entry_cnt), .start_ofs(start_ofs), .xfer_len(xfer_len),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .bst_valid(bst_valid), .bst_addr(bst_addr), .bst_len(bst_len),
    .bst_ready(bst_ready), .bst_done(bst_done), .bst_err(bst_err),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_sts(irq_sts), .irq_out(irq_out),
    .done(done), .err(err)
  );

  int checks = 0;
  int errors = 0;

  logic [63:0] d_addr [8];
  logic [31:0] d_flags [8];
  int          fail_idx = -1;
  int          cmd_base = 0;
  bit          stall_en = 1'b0;

  logic [63:0] log_a [1024];
  logic [22:0] log_l [1024];
  int          log_n = 0;

  logic [63:0] e_a [8];
  int          e_l [8];
  int          e_n;
  bit          e_err;
  bit          e_irq;

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem_word(rd_addr);
    end
  end

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    int i;
    i = int'((a - tbl_base) >> 4);
    if (i < 0 || i > 7) return 32'h0;
    case (a[3:0])
      4'h0: return d_addr[i][31:0];
      4'h4: return d_addr[i][63:32];
      4'hC: return d_flags[i];
      default: return 32'hDEAD_BEEF;
    endcase
  endfunction

  // data mover model
  bit mv_busy = 1'b0;
  int mv_cnt = 0;
  bit mv_err = 1'b0;
  always @(posedge clk) begin
    bst_done <= 1'b0;
    bst_err  <= 1'b0;
    if (rst) begin
      mv_busy <= 1'b0;
    end else if (mv_busy) begin
      if (mv_cnt == 0) begin
        bst_done <= 1'b1;
        bst_err  <= mv_err;
        mv_busy  <= 1'b0;
      end else begin
        mv_cnt <= mv_cnt - 1;
      end
    end else if (bst_valid && bst_ready) begin
      log_a[log_n % 1024] <= bst_addr;
      log_l[log_n % 1024] <= bst_len;
      mv_err  <= ((log_n - cmd_base) == fail_idx);
      log_n   <= log_n + 1;
      mv_busy <= 1'b1;
      mv_cnt  <= int'($urandom % 4);
    end
  end

  always @(negedge clk) bst_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model from the requirements
  task automatic model(input int n, input int ofs, input int xlen, input int fidx);
    int skip;
    int rem;
    bit pend;
    skip = ofs; rem = xlen; pend = 0; e_n = 0; e_err = 0;
    if (xlen != 0) begin
      for (int i = 0; i < n; i++) begin
        int len;
        int l;
        len = int'(d_flags[i][21:0]) + 1;
        if (skip >= len) begin
          skip -= len;
          continue;
        end
        l = len - skip;
        e_a[e_n] = d_addr[i] + 64'(skip);
        skip = 0;
        if (l > rem) l = rem;
        e_l[e_n] = l;
        e_n++;
        if (e_n - 1 == fidx) begin
          e_err = 1;
          break;
        end
        rem -= l;
        if (d_flags[i][31]) pend = 1;
        if (rem == 0) break;
      end
      if (!e_err && rem != 0) e_err = 1;
    end
    e_irq = !e_err && pend;
  endtask

  task automatic run_cmd(input string req, input int n, input int ofs, input int xlen,
                         input int fidx, input bit en, input bit mid_start, input bit clr_hold);
    @(negedge clk);
    model(n, ofs, xlen, fidx);
    fail_idx  = fidx;
    cmd_base  = log_n;
    irq_en    = en;
    irq_clr   = clr_hold;
    entry_cnt = 16'(n);
    start_ofs = 32'(ofs);
    xfer_len  = 32'(xlen);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      @(negedge clk);
      entry_cnt = 16'd1; start_ofs = 32'd0; xfer_len = 32'd4; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(log_n - cmd_base == e_n, req, "burst count", 64'(log_n - cmd_base), 64'(e_n));
    for (int k = 0; k < e_n && k < log_n - cmd_base; k++) begin
      chk(log_a[(cmd_base + k) % 1024] == e_a[k], req, "burst addr",
          log_a[(cmd_base + k) % 1024], e_a[k]);
      chk(int'(log_l[(cmd_base + k) % 1024]) == e_l[k], req, "burst len",
          64'(log_l[(cmd_base + k) % 1024]), 64'(e_l[k]));
    end
    chk(err == e_err, req, "err at done", 64'(err), 64'(e_err));
    chk(irq_sts == e_irq, req, "irq_sts at done", 64'(irq_sts), 64'(e_irq));
    @(negedge clk);
    chk(!done, "R10", "done one cycle", 64'(done), 64'(0));
    chk(err == e_err, "R10", "err held", 64'(err), 64'(e_err));
    if (clr_hold) begin
      chk(!irq_sts, "R9", "held clear after set", 64'(irq_sts), 64'(0));
    end else begin
      chk(irq_sts == e_irq, "R9", "irq_sts sticky", 64'(irq_sts), 64'(e_irq));
      chk(irq_out == (e_irq && en), "R9", "irq_out gating", 64'(irq_out), 64'(e_irq && en));
    end
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    @(negedge clk);
    chk(!irq_sts, "R9", "cleared by irq_clr", 64'(irq_sts), 64'(0));
  endtask

  task automatic set_desc(input int i, input logic [63:0] a, input int len, input bit ioc,
                          input logic [8:0] rsv);
    d_addr[i]  = a;
    d_flags[i] = {ioc, rsv, 22'(len - 1)};
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) set_desc(i, 64'h100 * (i + 1), 16, 1'b0, 9'h0);
    repeat (3) @(negedge clk);
    chk(!done && !err && !irq_sts && !bst_valid && !rd_en, "R1", "outputs in reset",
        {59'd0, done, err, irq_sts, bst_valid, rd_en}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !err && !irq_sts && !irq_out && !bst_valid && !rd_en, "R1",
        "outputs after reset", {58'd0, done, err, irq_sts, irq_out, bst_valid, rd_en}, 64'd0);

    // R3: plain three-descriptor walk, no flags
    set_desc(0, 64'h0000_0001_0000_0000, 512, 0, 9'h0);
    set_desc(1, 64'h0000_0002_0000_0010, 100, 0, 9'h0);
    set_desc(2, 64'h0000_0003_0000_0020, 4096, 0, 9'h0);
    run_cmd("R3", 3, 0, 512 + 100 + 4096, -1, 1, 0, 0);

    // R2 R8: reserved bits set everywhere, flag on middle descriptor
    set_desc(0, 64'h0000_0001_0000_0000, 64, 0, 9'h1FF);
    set_desc(1, 64'h0000_0002_0000_0010, 32, 1, 9'h155);
    set_desc(2, 64'h0000_0003_0000_0020, 8, 0, 9'h0AA);
    run_cmd("R2", 3, 0, 104, -1, 1, 0, 0);

    // R4 R8: offset inside descriptor 1, flag only on skipped descriptor 0
    set_desc(0, 64'h0000_0000_0000_8000, 40, 1, 9'h0);
    set_desc(1, 64'h0000_0000_0000_9000, 60, 0, 9'h0);
    set_desc(2, 64'h0000_0000_0000_A000, 20, 0, 9'h0);
    run_cmd("R4", 3, 50, 70, -1, 1, 0, 0);

    // R5: byte count cut in descriptor 1, flag on it, flag on unused descriptor 2
    set_desc(1, 64'h0000_0000_0000_9000, 60, 1, 9'h0);
    set_desc(2, 64'h0000_0000_0000_A000, 20, 1, 9'h0);
    run_cmd("R5", 3, 0, 70, -1, 1, 0, 0);

    // R6: table too short
    run_cmd("R6", 3, 0, 200, -1, 1, 0, 0);
    run_cmd("R6", 0, 0, 16, -1, 1, 0, 0);

    // R7: mover error on burst 1, flag on burst 0
    set_desc(0, 64'h0000_0000_0000_8000, 40, 1, 9'h0);
    run_cmd("R7", 3, 0, 120, 1, 1, 0, 0);

    // R5: zero-length command
    run_cmd("R5", 3, 0, 0, -1, 1, 0, 0);

    // R9: enable low, flagged success; then clear held across the set cycle
    run_cmd("R9", 3, 0, 120, -1, 0, 0, 0);
    run_cmd("R9", 3, 0, 120, -1, 1, 0, 1);

    // R10: start while busy is ignored
    run_cmd("R10", 3, 10, 100, -1, 1, 1, 0);

    // R11: reset in the middle of a flagged walk
    begin
      int base0;
      for (int i = 0; i < 8; i++) set_desc(i, 64'h2000 * (i + 1), 8, 1, 9'h0);
      @(negedge clk);
      fail_idx = -1; cmd_base = log_n; base0 = log_n;
      entry_cnt = 16'd8; start_ofs = 0; xfer_len = 64; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (log_n - base0 < 2) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      base0 = log_n;
      repeat (40) @(negedge clk);
      chk(log_n == base0, "R11", "no burst after reset", 64'(log_n - base0), 64'd0);
      chk(!irq_sts && !done && !err, "R11", "no status after reset",
          {61'd0, irq_sts, done, err}, 64'd0);
    end

    // random tables
    stall_en = 1'b1;
    void'($urandom(32'h5eed_1234));
    for (int t = 0; t < 40; t++) begin
      int n;
      int sum;
      int ofs;
      int xl;
      int fi;
      n = 1 + int'($urandom % 6);
      sum = 0;
      for (int i = 0; i < n; i++) begin
        int len;
        len = 1 + int'($urandom % 64);
        set_desc(i, {32'($urandom), 32'($urandom) & 32'hFFFF_FFFE}, len,
                 ($urandom % 3) == 0, 9'($urandom));
        sum += len;
      end
      ofs = int'($urandom % (sum + 1));
      xl  = int'($urandom % (sum - ofs + 12));
      fi  = (($urandom % 5) == 0) ? int'($urandom % 3) : -1;
      run_cmd("R8", n, ofs, xl, fi, ($urandom % 2) == 1, 0, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule